// File: doc/BRIEF.md
# Cascadable Event Counter Pair

This block holds two event counters, counter 0 and counter 1, each with a small control word. A counter runs when software sets its enable bit. It also runs when its cascade bit is set and its partner has overflowed. While it runs, it adds one for each qualifying event on its own input line. The event is either the line being high in a cycle, or, in edge mode, a false-to-true transition of the line. Each counter is the partner of the other.

A counter that passes its maximum value rolls over to zero and keeps counting. The rollover raises a sticky overflow flag, which stays set until software writes it low. Through the cascade bit, one counter's rollover can start the other counter, so the pair forms a longer or staged measurement.

Software reaches both control words and both counts through a single-cycle register port. Writes take effect on the next rising clock edge. Reads are combinational and never change any state.

Top module: `cascade_evt_pair`

## Requirements
- R1: With its enable bit (control bit 0) set, a counter adds one on every rising clock edge where its event input is high. With neither the enable bit nor the cascade run condition true, the count holds.
- R2: A counter that increments from the all-ones value goes to zero and continues counting from there.
- R3: Every rollover sets the counter's overflow flag (control bit 3). The flag stays set until a control write with bit 3 at 0 clears it.
- R4: A counter whose cascade bit (control bit 1) is set starts counting automatically once its partner's overflow flag is set, even though its own enable bit is clear.
- R5: A counter that runs only through cascade stops when software clears its cascade bit.
- R6: A counter that runs only through cascade stops when software clears the partner's overflow flag.
- R7: With edge mode (control bit 2) set, a counter adds one only on a low-to-high transition of its event input. A high period counts once, however long it lasts.
- R8: Register address 0 reads control word 0 and address 1 reads control word 1, with the four bits in positions 3..0 and zeros above. Address 2 reads count 0 and address 3 reads count 1. A read is valid at any time and does not change the counts.
- R9: A count write (address 2 or 3) in the same cycle as an increment loads the written value, and the increment is dropped.
- R10: A control write that clears the overflow flag in the same cycle as a rollover leaves the flag set.
- R11: Reset clears both counts and every control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; events are sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for both reads and writes |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Combinational read data for regAddr |
| evtIn | input | 2 | Qualified event inputs; bit i feeds counter i |

## Verification
A software write and an increment of the same counter can fall in one cycle. The bench provokes this in two ways while the event input is held high on a running counter. In the first, it writes a count value in that cycle; the read-back must equal the written value, not that value plus one. In the second, it writes a control word that clears the overflow flag in the cycle when the count rolls over from all ones; the read-back must show the flag set and the count at zero. The first also covers a cascaded counter, where clearing the partner's flag must stop it after that cycle's final increment.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NUM_CTR = 2;
  localparam int CTL_EN  = 0;
  localparam int CTL_CAS = 1;
  localparam int CTL_EDG = 2;
  localparam int CTL_OVF = 3;
  localparam int CTL_W   = 4;

  typedef enum logic [1:0] {
    ADDR_CTL0 = 2'd0,
    ADDR_CTL1 = 2'd1,
    ADDR_CNT0 = 2'd2,
    ADDR_CNT1 = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic [NUM_CTR-1:0] run;
    logic [NUM_CTR-1:0] edgeMode;
    logic [NUM_CTR-1:0] loadCnt;
  } dpStrobes_t;
endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [1:0]                     regAddr,
  input  logic [CTL_W-1:0]               ctlWrBits,
  input  logic [NUM_CTR-1:0]             wrap,
  output dpStrobes_t                     strobes,
  output logic [NUM_CTR-1:0][CTL_W-1:0]  ctlView
);
  logic [NUM_CTR-1:0][CTL_W-1:0] ctlReg;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctl
    localparam int PARTNER = i ^ 1;
    logic wrCtl;
    logic wrCnt;

    assign wrCtl = regWrEn && (regAddr == 2'(ADDR_CTL0 + i));
    assign wrCnt = regWrEn && (regAddr == 2'(ADDR_CNT0 + i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlReg[i] <= '0;
      end else begin
        if (wrCtl) begin
          ctlReg[i][CTL_EN]  <= ctlWrBits[CTL_EN];
          ctlReg[i][CTL_CAS] <= ctlWrBits[CTL_CAS];
          ctlReg[i][CTL_EDG] <= ctlWrBits[CTL_EDG];
        end
        ctlReg[i][CTL_OVF] <= wrap[i] | (wrCtl ? ctlWrBits[CTL_OVF] : ctlReg[i][CTL_OVF]);
      end
    end

    assign strobes.run[i]      = ctlReg[i][CTL_EN] |
                                 (ctlReg[i][CTL_CAS] & ctlReg[PARTNER][CTL_OVF]);
    assign strobes.edgeMode[i] = ctlReg[i][CTL_EDG];
    assign strobes.loadCnt[i]  = wrCnt;
    assign ctlView[i]          = ctlReg[i];

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rstN)
      wrap[i] |=> ctlView[i][CTL_OVF]); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (ctlView[i][CTL_OVF] && !wrCtl) |=> ctlView[i][CTL_OVF]); // R3
  end
endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobes_t                     strobes,
  input  logic [CNT_W-1:0]               loadData,
  input  logic [NUM_CTR-1:0]             evtIn,
  output logic [NUM_CTR-1:0]             wrap,
  output logic [NUM_CTR-1:0][CNT_W-1:0]  countOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic             prevLvl;
    logic             qualEvt;
    logic             incr;

    assign qualEvt = strobes.edgeMode[i] ? (evtIn[i] & ~prevLvl) : evtIn[i];
    assign incr    = strobes.run[i] & qualEvt;
    assign wrap[i] = incr & (cnt == CNT_MAX) & ~strobes.loadCnt[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt     <= '0;
        prevLvl <= 1'b0;
      end else begin
        prevLvl <= evtIn[i];
        if (strobes.loadCnt[i]) begin
          cnt <= loadData;
        end else if (incr) begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign countOut[i] = cnt;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.run[i] && !strobes.loadCnt[i]) |=> $stable(countOut[i])); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.loadCnt[i] |=> (countOut[i] == $past(countOut[i]) ||
                               countOut[i] == $past(countOut[i]) + 1'b1)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.loadCnt[i] |=> countOut[i] == $past(loadData)); // R9
  end
endmodule

// File: rtl/cascade_evt_pair.sv
module cascade_evt_pair
  import evc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic [1:0]       evtIn
);
  dpStrobes_t                     strobes;
  logic [NUM_CTR-1:0]             wrap;
  logic [NUM_CTR-1:0][CTL_W-1:0]  ctlView;
  logic [NUM_CTR-1:0][CNT_W-1:0]  countOut;

  evc_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .ctlWrBits (regWrData[CTL_W-1:0]),
    .wrap      (wrap),
    .strobes   (strobes),
    .ctlView   (ctlView)
  );

  evc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadData (regWrData),
    .evtIn    (evtIn),
    .wrap     (wrap),
    .countOut (countOut)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTL0: regRdData[CTL_W-1:0] = ctlView[0];
      ADDR_CTL1: regRdData[CTL_W-1:0] = ctlView[1];
      ADDR_CNT0: regRdData = countOut[0];
      default:   regRdData = countOut[1];
    endcase
  end
endmodule

// File: tb/cascade_evt_pair_tb_top.sv
`timescale 1ns/1ps
module cascade_evt_pair_tb_top;
  localparam int W = 40;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic [1:0]   evtIn = '0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  cascade_evt_pair #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    regAddr = a;
    #0.5;
    v = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R11 reset value", v, '0);
    end
  endtask

  task automatic t_level();
    logic [W-1:0] v;
    wr(2'd0, 40'h1);
    evtIn[0] = 1'b1;
    waitN(2);
    rd(2'd2, v); chk("R8 read while running", v, 40'd2);
    waitN(3);
    evtIn[0] = 1'b0;
    rd(2'd2, v); chk("R1 level count", v, 40'd5);
    waitN(2);
    rd(2'd2, v); chk("R1 low input holds", v, 40'd5);
    wr(2'd0, 40'h0);
    evtIn[0] = 1'b1;
    waitN(3);
    evtIn[0] = 1'b0;
    rd(2'd2, v); chk("R1 disabled holds", v, 40'd5);
    rd(2'd2, v); chk("R8 repeated read stable", v, 40'd5);
  endtask

  task automatic t_wrap();
    logic [W-1:0] v;
    wr(2'd2, MAXV - 1);
    wr(2'd0, 40'h1);
    evtIn[0] = 1'b1;
    waitN(3);
    evtIn[0] = 1'b0;
    rd(2'd2, v); chk("R2 wrap to zero and on", v, 40'd1);
    rd(2'd0, v); chk("R3 overflow set", v, 40'h9);
    waitN(4);
    rd(2'd0, v); chk("R3 overflow sticky", v, 40'h9);
    wr(2'd0, 40'h0);
    rd(2'd0, v); chk("R3 overflow cleared", v, 40'h0);
  endtask

  task automatic t_edge();
    logic [W-1:0] v;
    wr(2'd2, 40'd0);
    wr(2'd0, 40'h5);
    evtIn[0] = 1'b1; waitN(4);
    evtIn[0] = 1'b0; waitN(2);
    evtIn[0] = 1'b1; waitN(3);
    evtIn[0] = 1'b0; waitN(1);
    rd(2'd2, v); chk("R7 edge mode counts", v, 40'd2);
    wr(2'd0, 40'h0);
  endtask

  task automatic t_cascade();
    logic [W-1:0] v;
    logic [W-1:0] snap;
    wr(2'd2, 40'd0);
    wr(2'd0, 40'h2);
    wr(2'd3, MAXV);
    wr(2'd1, 40'h1);
    evtIn[0] = 1'b1;
    waitN(2);
    rd(2'd2, v); chk("R4 idle before partner overflow", v, 40'd0);
    evtIn[1] = 1'b1; waitN(1); evtIn[1] = 1'b0;
    rd(2'd2, v); chk("R4 not yet started", v, 40'd0);
    waitN(3);
    rd(2'd2, v); chk("R4 cascade started", v, 40'd3);
    rd(2'd1, v); chk("R4 partner overflow", v, 40'h9);
    wr(2'd1, 40'h1);
    rd(2'd2, snap);
    chk("R6 last count during clear", snap, 40'd4);
    waitN(3);
    rd(2'd2, v); chk("R6 stop on partner clear", v, snap);
    wr(2'd3, MAXV);
    evtIn[1] = 1'b1; waitN(1); evtIn[1] = 1'b0;
    waitN(2);
    rd(2'd2, v); chk("R5 restarted", v, snap + 2);
    wr(2'd0, 40'h0);
    rd(2'd2, snap);
    waitN(3);
    rd(2'd2, v); chk("R5 stop on cascade clear", v, snap);
    evtIn[0] = 1'b0;
    wr(2'd1, 40'h0);
  endtask

  task automatic t_collide();
    logic [W-1:0] v;
    wr(2'd0, 40'h1);
    evtIn[0] = 1'b1;
    waitN(2);
    wr(2'd2, 40'd100);
    rd(2'd2, v); chk("R9 write wins", v, 40'd100);
    waitN(1);
    rd(2'd2, v); chk("R9 counts after write", v, 40'd101);
    evtIn[0] = 1'b0;
    wr(2'd2, MAXV);
    wr(2'd0, 40'h9);
    evtIn[0] = 1'b1;
    wr(2'd0, 40'h1);
    evtIn[0] = 1'b0;
    rd(2'd0, v); chk("R10 wrap beats clear", v, 40'h9);
    rd(2'd2, v); chk("R10 count wrapped", v, 40'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_wrap();
    t_edge();
    t_cascade();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule